// File: doc/BRIEF.md
# Sampling-Phase Tuning Sweep Controller

This block picks the sampling phase for a high-speed card interface. On a start request it walks a 7-bit delay-line setting upward from zero in steps of four. For every setting it enables the forced-value path of the delay line, presents the value, and raises a calibrate request. It then waits for the calibrate status or a poll limit, drops the request, and asks an external requester for one tuning transfer. It keeps the longest unbroken run of passing settings. After the sweep it programs the middle of that run through the same handshake.

Tuning is skipped, and success is reported at once, when the bus clock is slow enough not to need it. It is also skipped when the interface is in its 50 MHz mode and the capability input says that mode needs no tuning. If no setting passes, or if the tuned-clock select status is low at the end of the sweep, the block reports an error. It then withdraws the forced value and the tuning enable and clears the tuned-clock select. Every tuning run that is not skipped ends with a one-cycle command/data reset pulse, which comes just before done.

Top module: `phase_sweep_tuner`

## Requirements
- R1: When `start` is seen and `busClkKhz` is at or below 52000, `done` pulses with `errFlag` low. No tuning request, calibrate request or reset pulse is issued, and `tuneEn` stays low.
- R2: When `modeSdr50` is high and `capTuneSdr50` is low, start is skipped as in R1. With `capTuneSdr50` high the full sweep runs.
- R3: `tuneEn` goes high before the first tuning request and stays high through a successful run.
- R4: Each calibrate request rises only while `forceVal` is high, and `dlyValue` holds steady while `calibReq` is high.
- R5: `calibReq` falls in the cycle after `calibDone` is seen high. If `calibDone` never comes, it falls after exactly 1000 cycles high.
- R6: A sweep issues exactly 32 tuning requests, with `dlyValue` equal to 0, 4, 8, … 124 in that order.
- R7: The final `dlyValue` is S + 4*(L>>1), where L is the longest run of consecutive passing settings and S is its first setting. On a tie in length, the earliest run is kept.
- R8: If no setting passes, `errFlag` is high at `done`, `forceVal` and `tuneEn` are low, and `tunedClkOff` has pulsed.
- R9: If `tunedClkSel` is low at the end of the sweep, the outcome is as in R8, even when settings passed.
- R10: Every run that is not skipped, whether it succeeds or fails, gives one `cmdDatRst` pulse of one cycle in the cycle directly before `done`.
- R11: A cycle with `powerOff` high clears `tuneEn` and `forceVal` on the next edge.
- R12: `done` is a one-cycle pulse, and `errFlag` is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a tuning request |
| busClkKhz | input | 20 | Current bus clock rate in kHz |
| modeSdr50 | input | 1 | Interface is in its 50 MHz mode |
| capTuneSdr50 | input | 1 | Capability: the 50 MHz mode needs tuning |
| tunedClkSel | input | 1 | Status: tuned clock selected |
| powerOff | input | 1 | Card power being removed |
| calibDone | input | 1 | Delay-line calibrate status |
| tuneAck | input | 1 | Tuning transfer finished |
| tunePass | input | 1 | Result of the transfer, valid with tuneAck |
| tuneReq | output | 1 | Request one tuning transfer |
| dlyValue | output | 7 | Delay-line setting |
| forceVal | output | 1 | Forced-value enable of the delay line |
| calibReq | output | 1 | Calibrate request |
| tuneEn | output | 1 | Software tuning enable |
| tunedClkOff | output | 1 | One-cycle pulse that clears the tuned-clock select |
| cmdDatRst | output | 1 | One-cycle command/data reset request |
| done | output | 1 | Run finished |
| errFlag | output | 1 | Run ended in error |

## Verification
The sweep is driven with pass patterns that separate each part of the window logic. An all-fail pattern checks the error path. An all-pass pattern checks the largest centre. A single passing setting checks that a run of length one keeps its own start. Two equal runs check that the earliest run wins a tie. A longer later run checks that a better run replaces the best. A run ending at the last setting checks the top boundary. A run spread over alternating passes checks that the length resets after a fail. Runs with a slow clock, with the 50 MHz mode both with and without the capability bit, and with a low clock-select status separate the skip and error exits from the normal one. A run with calibration that never answers checks the 1000-cycle poll limit.

// File: rtl/pst_pkg.sv
package pst_pkg;
  typedef struct packed {
    logic initSweep;
    logic applyDly;
    logic pollClr;
    logic pollInc;
    logic record;
    logic stepDly;
    logic loadFinal;
    logic shutOff;
  } strobe_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SKIP,
    ST_LOAD,
    ST_CAL,
    ST_CALEND,
    ST_REQ,
    ST_EVAL,
    ST_DISABLE,
    ST_RST,
    ST_DONE
  } state_t;
endpackage

// File: rtl/pst_dpath.sv
module pst_dpath #(
  parameter int DLY_W = 7,
  parameter int STEP = 4,
  parameter int MAX_DLY = 124,
  parameter int POLL_LIMIT = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  pst_pkg::strobe_t stb,
  input  logic passIn,
  input  logic powerOff,
  output logic [DLY_W-1:0] dlyValue,
  output logic forceVal,
  output logic tuneEn,
  output logic atLastStep,
  output logic pollExpired,
  output logic noPass
);
  localparam int STEPS = MAX_DLY / STEP + 1;
  localparam int LEN_W = $clog2(STEPS + 1);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);
  localparam int SUM_W = DLY_W + 2;

  logic [DLY_W-1:0] dlyReg, curStart, bestStart;
  logic [LEN_W-1:0] curLen, bestLen;
  logic prevPass;
  logic [POLL_W-1:0] pollCnt;
  logic [LEN_W-1:0] runLen;
  logic [DLY_W-1:0] runStart;
  logic [SUM_W-1:0] centreSum;

  always_comb begin
    runLen = prevPass ? curLen + LEN_W'(1) : LEN_W'(1);
    runStart = prevPass ? curStart : dlyReg;
    centreSum = SUM_W'(bestStart) + SUM_W'(STEP) * SUM_W'(bestLen >> 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyReg <= '0;
      curStart <= '0;
      bestStart <= '0;
      curLen <= '0;
      bestLen <= '0;
      prevPass <= 1'b0;
    end else if (stb.initSweep) begin
      dlyReg <= '0;
      curStart <= '0;
      bestStart <= '0;
      curLen <= '0;
      bestLen <= '0;
      prevPass <= 1'b0;
    end else begin
      if (stb.record) begin
        prevPass <= passIn;
        if (passIn) begin
          curLen <= runLen;
          curStart <= runStart;
          if (runLen > bestLen) begin
            bestLen <= runLen;
            bestStart <= runStart;
          end
        end else begin
          curLen <= '0;
        end
      end
      if (stb.stepDly) dlyReg <= dlyReg + DLY_W'(STEP);
      else if (stb.loadFinal) dlyReg <= centreSum[DLY_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pollCnt <= '0;
    else if (stb.pollClr) pollCnt <= '0;
    else if (stb.pollInc) pollCnt <= pollCnt + POLL_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      forceVal <= 1'b0;
      tuneEn <= 1'b0;
    end else if (powerOff || stb.shutOff) begin
      forceVal <= 1'b0;
      tuneEn <= 1'b0;
    end else begin
      if (stb.initSweep) tuneEn <= 1'b1;
      if (stb.applyDly) forceVal <= 1'b1;
    end
  end

  assign dlyValue = dlyReg;
  assign atLastStep = (dlyReg == DLY_W'(MAX_DLY));
  assign pollExpired = (pollCnt == POLL_W'(POLL_LIMIT - 1));
  assign noPass = (bestLen == '0);
endmodule

// File: rtl/pst_ctrl.sv
module pst_ctrl #(
  parameter int CLK_W = 20,
  parameter int SLOW_KHZ = 52000
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic [CLK_W-1:0] busClkKhz,
  input  logic modeSdr50,
  input  logic capTuneSdr50,
  input  logic tunedClkSel,
  input  logic calibDone,
  input  logic tuneAck,
  input  logic atLastStep,
  input  logic pollExpired,
  input  logic noPass,
  output pst_pkg::strobe_t stb,
  output logic calibReq,
  output logic tuneReq,
  output logic tunedClkOff,
  output logic cmdDatRst,
  output logic done,
  output logic errFlag
);
  import pst_pkg::*;

  state_t state, nextState;
  logic finalPhase;
  logic errReg;
  logic skipRun;

  assign skipRun = (busClkKhz <= CLK_W'(SLOW_KHZ)) || (modeSdr50 && !capTuneSdr50);

  always_comb begin
    nextState = state;
    stb = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        if (skipRun) nextState = ST_SKIP;
        else begin
          stb.initSweep = 1'b1;
          nextState = ST_LOAD;
        end
      end
      ST_SKIP: nextState = ST_IDLE;
      ST_LOAD: begin
        stb.applyDly = 1'b1;
        stb.pollClr = 1'b1;
        nextState = ST_CAL;
      end
      ST_CAL: begin
        stb.pollInc = 1'b1;
        if (calibDone || pollExpired) nextState = ST_CALEND;
      end
      ST_CALEND: nextState = finalPhase ? ST_RST : ST_REQ;
      ST_REQ: if (tuneAck) begin
        stb.record = 1'b1;
        if (atLastStep) nextState = ST_EVAL;
        else begin
          stb.stepDly = 1'b1;
          nextState = ST_LOAD;
        end
      end
      ST_EVAL: begin
        if (noPass || !tunedClkSel) nextState = ST_DISABLE;
        else begin
          stb.loadFinal = 1'b1;
          nextState = ST_LOAD;
        end
      end
      ST_DISABLE: begin
        stb.shutOff = 1'b1;
        nextState = ST_RST;
      end
      ST_RST: nextState = ST_DONE;
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      finalPhase <= 1'b0;
      errReg <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && start) begin
        finalPhase <= 1'b0;
        errReg <= 1'b0;
      end
      if (state == ST_EVAL) begin
        if (noPass || !tunedClkSel) errReg <= 1'b1;
        else finalPhase <= 1'b1;
      end
    end
  end

  assign calibReq = (state == ST_CAL);
  assign tuneReq = (state == ST_REQ);
  assign tunedClkOff = (state == ST_DISABLE);
  assign cmdDatRst = (state == ST_RST);
  assign done = (state == ST_DONE) || (state == ST_SKIP);
  assign errFlag = errReg;
endmodule

// File: rtl/phase_sweep_tuner.sv
module phase_sweep_tuner #(
  parameter int DLY_W = 7,
  parameter int STEP = 4,
  parameter int MAX_DLY = 124,
  parameter int POLL_LIMIT = 1000,
  parameter int CLK_W = 20,
  parameter int SLOW_KHZ = 52000
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic [CLK_W-1:0] busClkKhz,
  input  logic modeSdr50,
  input  logic capTuneSdr50,
  input  logic tunedClkSel,
  input  logic powerOff,
  input  logic calibDone,
  input  logic tuneAck,
  input  logic tunePass,
  output logic tuneReq,
  output logic [DLY_W-1:0] dlyValue,
  output logic forceVal,
  output logic calibReq,
  output logic tuneEn,
  output logic tunedClkOff,
  output logic cmdDatRst,
  output logic done,
  output logic errFlag
);
  pst_pkg::strobe_t stb;
  logic atLastStep, pollExpired, noPass;

  pst_ctrl #(.CLK_W(CLK_W), .SLOW_KHZ(SLOW_KHZ)) ctrlInst (
    .clk(clk), .rstN(rstN), .start(start), .busClkKhz(busClkKhz),
    .modeSdr50(modeSdr50), .capTuneSdr50(capTuneSdr50), .tunedClkSel(tunedClkSel),
    .calibDone(calibDone), .tuneAck(tuneAck), .atLastStep(atLastStep),
    .pollExpired(pollExpired), .noPass(noPass), .stb(stb), .calibReq(calibReq),
    .tuneReq(tuneReq), .tunedClkOff(tunedClkOff), .cmdDatRst(cmdDatRst),
    .done(done), .errFlag(errFlag)
  );

  pst_dpath #(.DLY_W(DLY_W), .STEP(STEP), .MAX_DLY(MAX_DLY), .POLL_LIMIT(POLL_LIMIT)) dpathInst (
    .clk(clk), .rstN(rstN), .stb(stb), .passIn(tunePass), .powerOff(powerOff),
    .dlyValue(dlyValue), .forceVal(forceVal), .tuneEn(tuneEn),
    .atLastStep(atLastStep), .pollExpired(pollExpired), .noPass(noPass)
  );
endmodule

// File: rtl/pst_checker.sv
module pst_checker #(
  parameter int DLY_W = 7
) (
  input logic clk,
  input logic rstN,
  input logic calibReq,
  input logic forceVal,
  input logic [DLY_W-1:0] dlyValue,
  input logic cmdDatRst,
  input logic done,
  input logic tunedClkOff,
  input logic powerOff,
  input logic tuneEn
);
  AST_CAL_WITH_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calibReq) |-> forceVal); // R4
  AST_DLY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (calibReq && $past(calibReq)) |-> $stable(dlyValue)); // R4
  AST_RST_THEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    cmdDatRst |=> (done && !cmdDatRst)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R12
  AST_CLKOFF_SHUTS: assert property (@(posedge clk) disable iff (!rstN)
    tunedClkOff |=> (!forceVal && !tuneEn && cmdDatRst)); // R8
  AST_POWER_DROP: assert property (@(posedge clk) disable iff (!rstN)
    powerOff |=> (!forceVal && !tuneEn)); // R11
endmodule

bind phase_sweep_tuner pst_checker #(.DLY_W(DLY_W)) chk (
  .clk(clk), .rstN(rstN), .calibReq(calibReq), .forceVal(forceVal),
  .dlyValue(dlyValue), .cmdDatRst(cmdDatRst), .done(done),
  .tunedClkOff(tunedClkOff), .powerOff(powerOff), .tuneEn(tuneEn)
);

// File: tb/phase_sweep_tuner_test.sv
`timescale 1ns/1ps
module phase_sweep_tuner_test;
  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [19:0] busClkKhz = 20'd200000;
  logic modeSdr50 = 1'b0, capTuneSdr50 = 1'b0, tunedClkSel = 1'b1, powerOff = 1'b0;
  logic calibDone = 1'b0, tuneAck = 1'b0, tunePass = 1'b0;
  logic tuneReq, forceVal, calibReq, tuneEn, tunedClkOff, cmdDatRst, done, errFlag;
  logic [6:0] dlyValue;

  int tests = 0, fails = 0, cycles = 0;
  logic [31:0] pattern = '0;
  int calibLat = 3;
  bit calibAnswers = 1'b1;
  int calCnt = 0, calLenMax = 0, reqCount = 0, orderErr = 0, calibCount = 0;
  bit rstSeen = 1'b0, clkOffSeen = 1'b0, enBeforeReq = 1'b1;

  always #10 clk = ~clk;

  phase_sweep_tuner uut (
    .clk(clk), .rstN(rstN), .start(start), .busClkKhz(busClkKhz),
    .modeSdr50(modeSdr50), .capTuneSdr50(capTuneSdr50), .tunedClkSel(tunedClkSel),
    .powerOff(powerOff), .calibDone(calibDone), .tuneAck(tuneAck), .tunePass(tunePass),
    .tuneReq(tuneReq), .dlyValue(dlyValue), .forceVal(forceVal), .calibReq(calibReq),
    .tuneEn(tuneEn), .tunedClkOff(tunedClkOff), .cmdDatRst(cmdDatRst),
    .done(done), .errFlag(errFlag)
  );

  // Responders and monitors, all on the falling edge
  always @(negedge clk) begin
    cycles++;
    if (calibReq) begin
      if (calCnt == 0) calibCount++;
      calCnt++;
      if (calCnt > calLenMax) calLenMax = calCnt;
      calibDone <= calibAnswers && (calCnt >= calibLat);
    end else begin
      calCnt = 0;
      calibDone <= 1'b0;
    end
    if (tuneReq && !tuneAck) begin
      if (int'(dlyValue) != 4 * reqCount) orderErr++;
      if (!tuneEn) enBeforeReq = 1'b0;
      tunePass <= pattern[dlyValue >> 2];
      tuneAck <= 1'b1;
      reqCount++;
    end else tuneAck <= 1'b0;
    if (cmdDatRst) rstSeen = 1'b1;
    if (tunedClkOff) clkOffSeen = 1'b1;
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expCentre(input logic [31:0] p);
    int bs = 0, bl = 0, cs = 0, cl = 0;
    for (int i = 0; i < 32; i++) begin
      if (p[i]) begin
        if (cl == 0) cs = 4 * i;
        cl++;
        if (cl > bl) begin bl = cl; bs = cs; end
      end else cl = 0;
    end
    return bs + 4 * (bl / 2);
  endfunction

  int doneErr, doneDly, doneLen;

  task automatic runTune;
    reqCount = 0; orderErr = 0; calLenMax = 0; calibCount = 0;
    rstSeen = 1'b0; clkOffSeen = 1'b0; enBeforeReq = 1'b1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    doneLen = 0;
    while (!done) @(negedge clk);
    doneErr = errFlag;
    doneDly = dlyValue;
    @(negedge clk) doneLen = done ? 2 : 1;
  endtask

  task automatic sweepCase(input string tag, input logic [31:0] p);
    pattern = p;
    runTune();
    check({tag, " R7 error flag"}, doneErr, (p == 0) ? 1 : 0);
    if (p != 0) check({tag, " R7 centre"}, doneDly, expCentre(p));
    check({tag, " R6 request count"}, reqCount, 32);
    check({tag, " R6 order"}, orderErr, 0);
    check({tag, " R10 reset pulse"}, int'(rstSeen), 1);
    check({tag, " R12 done width"}, doneLen, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset done", int'(done), 0);
    check("R3 reset tuneEn", int'(tuneEn), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: slow clock skip
    busClkKhz = 20'd52000; pattern = '1;
    runTune();
    check("R1 skip err", doneErr, 0);
    check("R1 skip no request", reqCount + calibCount, 0);
    check("R1 skip no reset", int'(rstSeen), 0);
    check("R1 skip tuneEn", int'(tuneEn), 0);
    busClkKhz = 20'd200000;

    // R2: 50 MHz mode without capability skips, with it sweeps
    modeSdr50 = 1'b1; capTuneSdr50 = 1'b0;
    runTune();
    check("R2 skip request count", reqCount, 0);
    check("R2 skip err", doneErr, 0);
    capTuneSdr50 = 1'b1;
    sweepCase("R2 sweep", 32'h0000_FF00);
    modeSdr50 = 1'b0;

    // R7: window patterns
    sweepCase("allpass", 32'hFFFF_FFFF);
    check("R3 tuneEn held", int'(tuneEn), 1);
    check("R3 enable before request", int'(enBeforeReq), 1);
    check("R4 forceVal held", int'(forceVal), 1);
    check("R5 calib length latency", calLenMax, calibLat);
    check("R5 calibrations", calibCount, 33);
    sweepCase("single", 32'h0000_0400);
    sweepCase("tie", 32'h00F0_000F);
    sweepCase("longer later", 32'hFF00_0070);
    sweepCase("top edge", 32'hC000_0000);
    sweepCase("alternating", 32'h5555_5555);
    sweepCase("gap", 32'h0001_BF7E);

    // R8: nothing passes
    sweepCase("R8 none", 32'h0);
    check("R8 forceVal off", int'(forceVal), 0);
    check("R8 tuneEn off", int'(tuneEn), 0);
    check("R8 clock select cleared", int'(clkOffSeen), 1);

    // R9: clock select status low
    tunedClkSel = 1'b0; pattern = 32'h00FF_0000;
    runTune();
    check("R9 error", doneErr, 1);
    check("R9 tuneEn off", int'(tuneEn), 0);
    check("R9 clock select cleared", int'(clkOffSeen), 1);
    check("R10 reset on error", int'(rstSeen), 1);
    tunedClkSel = 1'b1;

    // R5: calibration never answers
    calibAnswers = 1'b0;
    sweepCase("R5 timeout", 32'h0000_0FF0);
    check("R5 poll limit", calLenMax, 1000);
    calibAnswers = 1'b1;

    // R11: power off clears enables
    sweepCase("R11 prep", 32'h0000_00FF);
    check("R11 enabled before", int'(tuneEn & forceVal), 1);
    @(negedge clk) powerOff = 1'b1;
    @(negedge clk) powerOff = 1'b0;
    check("R11 tuneEn cleared", int'(tuneEn), 0);
    check("R11 forceVal cleared", int'(forceVal), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    while (cycles < 190000) @(negedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule